// File: doc/BRIEF.md
# Cascadable Operand Input Stage

This block is the operand entry point of a multiply-add slice. It takes one operand either from a direct data port or from a cascade port. The cascade port is meant to be driven by the cascade output of an identical stage in a neighbouring slice. The chosen operand then passes through a register chain of zero, one or two stages, and the end of that chain feeds the datapath.

A second output, the cascade tap, is taken from the same chain at a shallower or equal depth. That lets a row of slices share one operand with staggered timing, and it adds no registers.

Each register has its own clock enable, and a synchronous clear zeroes the chain. A build option replaces the local clear and both enables with one global clear and one global enable. An asynchronous active-low reset also clears the chain. A tap depth greater than the chain depth, or a chain depth above two, stops elaboration with an error.

Top module: `opnd_cascade_stage`

## Requirements
- R1: Parameter SRC_CASC selects the operand source. A value of 0 takes direct_i and a value of 1 takes casc_i. The input that is not selected has no effect on either output.
- R2: With DEPTH = 0, oper_o equals the selected input in the same cycle, with no register in the path.
- R3: With DEPTH = 2, a value sampled by two enabled edges appears on oper_o after the second edge. With DEPTH = 1, it appears after the first edge.
- R4: casc_o is the chain register at depth CASC_DEPTH. A CASC_DEPTH of 0 gives the selected input unregistered. When CASC_DEPTH equals DEPTH, casc_o equals oper_o.
- R5: en1_i gates the first register and en2_i gates the second. A register whose enable is low holds its value. With DEPTH = 1, the single register uses en1_i.
- R6: When clr_i is 1 at a rising edge, every chain register becomes 0 at that edge, whatever the enables are.
- R7: With HAS_GLOBAL = 1, glb_clr_i replaces clr_i and glb_en_i replaces both en1_i and en2_i. clr_i, en1_i and en2_i then have no effect.
- R8: With HAS_GLOBAL = 0, glb_clr_i and glb_en_i have no effect on either output.
- R9: While rst_ni is 0, every chain register is 0, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| direct_i | input | W | Direct operand input |
| casc_i | input | W | Operand from the neighbour's cascade tap |
| en1_i | input | 1 | Enable of the first register |
| en2_i | input | 1 | Enable of the second register |
| clr_i | input | 1 | Synchronous clear, active high |
| glb_en_i | input | 1 | Global enable (used when HAS_GLOBAL = 1) |
| glb_clr_i | input | 1 | Global synchronous clear (used when HAS_GLOBAL = 1) |
| oper_o | output | W | Delayed operand to the datapath |
| casc_o | output | W | Cascade tap for the next stage |

## Verification
The results fall due at different points:
- A pass-through output (DEPTH = 0, or a tap of depth 0) follows its input in the same cycle.
- A depth-1 output changes at the first rising edge after an enabled sample.
- A depth-2 output changes one enabled edge later than that.

The bench keeps reference registers that are updated at each rising edge from the requirements alone. It drives inputs and compares outputs only at falling edges, so each comparison sees exactly the edges that have elapsed. Reset is checked a short delay after rst_ni falls, with no edge in between.

// File: rtl/opnd_stage_pkg.sv
package opnd_stage_pkg;
  typedef struct packed {
    logic clr;
    logic en1;
    logic en2;
  } stage_ctrl_t;

  localparam int unsigned MAX_DEPTH = 2;
endpackage

// File: rtl/opnd_src_sel.sv
module opnd_src_sel #(
  parameter int unsigned W        = 30,
  parameter bit          SRC_CASC = 1'b0
) (
  input  logic [W-1:0] direct_i,
  input  logic [W-1:0] casc_i,
  output logic [W-1:0] sel_o
);
  logic unused_in;

  if (SRC_CASC) begin : g_casc
    assign sel_o     = casc_i;
    assign unused_in = ^direct_i;
  end else begin : g_direct
    assign sel_o     = direct_i;
    assign unused_in = ^casc_i;
  end
endmodule

// File: rtl/opnd_ctrl_res.sv
module opnd_ctrl_res
  import opnd_stage_pkg::*;
#(
  parameter bit HAS_GLOBAL = 1'b0
) (
  input  logic        en1_i,
  input  logic        en2_i,
  input  logic        clr_i,
  input  logic        glb_en_i,
  input  logic        glb_clr_i,
  output stage_ctrl_t ctrl_o
);
  logic unused_ctrl;

  if (HAS_GLOBAL) begin : g_global
    // global pins override every local clear and enable
    assign ctrl_o.clr  = glb_clr_i;
    assign ctrl_o.en1  = glb_en_i;
    assign ctrl_o.en2  = glb_en_i;
    assign unused_ctrl = ^{en1_i, en2_i, clr_i};
  end else begin : g_local
    assign ctrl_o.clr  = clr_i;
    assign ctrl_o.en1  = en1_i;
    assign ctrl_o.en2  = en2_i;
    assign unused_ctrl = ^{glb_en_i, glb_clr_i};
  end
endmodule

// File: rtl/opnd_pipe_reg.sv
module opnd_pipe_reg #(
  parameter int unsigned W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (clr_i) begin
      // clear wins over enable
      q_o <= '0;
    end else if (en_i) begin
      q_o <= d_i;
    end
  end
endmodule

// File: rtl/opnd_cascade_stage.sv
module opnd_cascade_stage
  import opnd_stage_pkg::*;
#(
  parameter int unsigned W          = 30,
  parameter int unsigned DEPTH      = 2,
  parameter int unsigned CASC_DEPTH = 1,
  parameter bit          SRC_CASC   = 1'b0,
  parameter bit          HAS_GLOBAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] direct_i,
  input  logic [W-1:0] casc_i,
  input  logic         en1_i,
  input  logic         en2_i,
  input  logic         clr_i,
  input  logic         glb_en_i,
  input  logic         glb_clr_i,
  output logic [W-1:0] oper_o,
  output logic [W-1:0] casc_o
);
  localparam int unsigned NTAP = DEPTH + 1;

  if (DEPTH > MAX_DEPTH || CASC_DEPTH > DEPTH) begin : g_bad_cfg
    $error("opnd_cascade_stage: needs DEPTH <= 2 and CASC_DEPTH <= DEPTH");
  end

  stage_ctrl_t ctrl;
  logic [W-1:0] tap [NTAP];

  opnd_src_sel #(
    .W        (W),
    .SRC_CASC (SRC_CASC)
  ) u_src_sel (
    .direct_i (direct_i),
    .casc_i   (casc_i),
    .sel_o    (tap[0])
  );

  opnd_ctrl_res #(
    .HAS_GLOBAL (HAS_GLOBAL)
  ) u_ctrl_res (
    .en1_i     (en1_i),
    .en2_i     (en2_i),
    .clr_i     (clr_i),
    .glb_en_i  (glb_en_i),
    .glb_clr_i (glb_clr_i),
    .ctrl_o    (ctrl)
  );

  for (genvar i = 1; i < NTAP; i++) begin : g_stage
    logic stg_en;
    // stage 1 uses en1, stage 2 uses en2
    assign stg_en = (i == 1) ? ctrl.en1 : ctrl.en2;

    opnd_pipe_reg #(
      .W (W)
    ) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (ctrl.clr),
      .en_i   (stg_en),
      .d_i    (tap[i-1]),
      .q_o    (tap[i])
    );
  end

  // tap shares the main chain, no extra registers
  assign oper_o = tap[DEPTH];
  assign casc_o = tap[CASC_DEPTH];
endmodule

// File: rtl/opnd_cascade_stage_chk.sv
module opnd_cascade_stage_chk #(
  parameter int unsigned W          = 30,
  parameter int unsigned DEPTH      = 2,
  parameter int unsigned CASC_DEPTH = 1,
  parameter bit          SRC_CASC   = 1'b0,
  parameter bit          HAS_GLOBAL = 1'b0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] direct_i,
  input logic [W-1:0] casc_i,
  input logic         en1_i,
  input logic         en2_i,
  input logic         clr_i,
  input logic         glb_en_i,
  input logic         glb_clr_i,
  input logic [W-1:0] oper_o,
  input logic [W-1:0] casc_o
);
  logic         k_clr, k_en1, k_en2, k_last;
  logic [W-1:0] k_src;

  assign k_clr  = HAS_GLOBAL ? glb_clr_i : clr_i;
  assign k_en1  = HAS_GLOBAL ? glb_en_i  : en1_i;
  assign k_en2  = HAS_GLOBAL ? glb_en_i  : en2_i;
  assign k_last = (DEPTH == 2) ? k_en2 : k_en1;
  assign k_src  = SRC_CASC ? casc_i : direct_i;

  if (DEPTH == 0) begin : g_pass
    AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oper_o == k_src); // R2
  end else begin : g_reg
    AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      k_clr |=> oper_o == '0); // R6
    AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!k_clr && !k_last) |=> $stable(oper_o)); // R5
  end

  if (DEPTH == 1) begin : g_one
    AST_LOAD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!k_clr && k_en1) |=> oper_o == $past(k_src)); // R3
  end

  if (CASC_DEPTH == DEPTH) begin : g_same
    AST_CASC_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      casc_o == oper_o); // R4
  end

  if (CASC_DEPTH == 0) begin : g_raw
    AST_CASC_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      casc_o == k_src); // R4
  end
endmodule

bind opnd_cascade_stage opnd_cascade_stage_chk #(
  .W          (W),
  .DEPTH      (DEPTH),
  .CASC_DEPTH (CASC_DEPTH),
  .SRC_CASC   (SRC_CASC),
  .HAS_GLOBAL (HAS_GLOBAL)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .direct_i  (direct_i),
  .casc_i    (casc_i),
  .en1_i     (en1_i),
  .en2_i     (en2_i),
  .clr_i     (clr_i),
  .glb_en_i  (glb_en_i),
  .glb_clr_i (glb_clr_i),
  .oper_o    (oper_o),
  .casc_o    (casc_o)
);

// File: tb/opnd_cascade_stage_bench.sv
`timescale 1ns/1ps
module opnd_cascade_stage_bench;
  localparam int unsigned W = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] direct, casc;
  logic en1, en2, clr, glb_en, glb_clr;
  logic [W-1:0] a_op, a_cs, b_op, b_cs, c_op, c_cs, d_op, d_cs;
  logic [W-1:0] a1, a2, c1, c2, d1;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // A: depth 2, tap 1, direct source, local controls
  opnd_cascade_stage #(.W(W), .DEPTH(2), .CASC_DEPTH(1), .SRC_CASC(1'b0), .HAS_GLOBAL(1'b0))
    u_opnd_cascade_stage (.clk_i(clk), .rst_ni(rst_n), .direct_i(direct), .casc_i(casc),
      .en1_i(en1), .en2_i(en2), .clr_i(clr), .glb_en_i(glb_en), .glb_clr_i(glb_clr),
      .oper_o(a_op), .casc_o(a_cs));
  // B: pass-through, cascade source
  opnd_cascade_stage #(.W(W), .DEPTH(0), .CASC_DEPTH(0), .SRC_CASC(1'b1), .HAS_GLOBAL(1'b0))
    u_pass (.clk_i(clk), .rst_ni(rst_n), .direct_i(direct), .casc_i(casc),
      .en1_i(en1), .en2_i(en2), .clr_i(clr), .glb_en_i(glb_en), .glb_clr_i(glb_clr),
      .oper_o(b_op), .casc_o(b_cs));
  // C: depth 2, tap 2, cascade source, global controls
  opnd_cascade_stage #(.W(W), .DEPTH(2), .CASC_DEPTH(2), .SRC_CASC(1'b1), .HAS_GLOBAL(1'b1))
    u_glb (.clk_i(clk), .rst_ni(rst_n), .direct_i(direct), .casc_i(casc),
      .en1_i(en1), .en2_i(en2), .clr_i(clr), .glb_en_i(glb_en), .glb_clr_i(glb_clr),
      .oper_o(c_op), .casc_o(c_cs));
  // D: depth 1, tap 0, direct source
  opnd_cascade_stage #(.W(W), .DEPTH(1), .CASC_DEPTH(0), .SRC_CASC(1'b0), .HAS_GLOBAL(1'b0))
    u_one (.clk_i(clk), .rst_ni(rst_n), .direct_i(direct), .casc_i(casc),
      .en1_i(en1), .en2_i(en2), .clr_i(clr), .glb_en_i(glb_en), .glb_clr_i(glb_clr),
      .oper_o(d_op), .casc_o(d_cs));

  // reference registers built from the requirements
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1 <= '0; a2 <= '0; c1 <= '0; c2 <= '0; d1 <= '0;
    end else begin
      if (clr) begin
        a1 <= '0; a2 <= '0; d1 <= '0;
      end else begin
        if (en1) a1 <= direct;
        if (en2) a2 <= a1;
        if (en1) d1 <= direct;
      end
      if (glb_clr) begin
        c1 <= '0; c2 <= '0;
      end else if (glb_en) begin
        c1 <= casc; c2 <= c1;
      end
    end
  end

  task automatic cmp(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    cmp(a_op, a2, "R3 R5 R6 R8 depth2 oper");
    cmp(a_cs, a1, "R4 R5 tap1");
    cmp(b_op, casc, "R1 R2 pass oper");
    cmp(b_cs, casc, "R4 pass tap");
    cmp(c_op, c2, "R7 global oper");
    cmp(c_cs, c2, "R4 R7 tap equals oper");
    cmp(d_op, d1, "R3 R5 depth1 oper");
    cmp(d_cs, direct, "R1 R4 tap0 raw");
  endtask

  task automatic step(input logic [W-1:0] dv, input logic [W-1:0] cv,
                      input logic e1, input logic e2, input logic cl,
                      input logic ge, input logic gc);
    @(negedge clk);
    check_all();
    direct = dv; casc = cv; en1 = e1; en2 = e2; clr = cl; glb_en = ge; glb_clr = gc;
  endtask

  initial begin
    void'($urandom(32'd4242));
    direct = '0; casc = '0; en1 = 0; en2 = 0; clr = 0; glb_en = 0; glb_clr = 0;
    #1;
    // R9: registered outputs are zero during reset
    cmp(a_op, '0, "R9 reset oper");
    cmp(a_cs, '0, "R9 reset tap");
    cmp(c_op, '0, "R9 reset global");
    cmp(d_op, '0, "R9 reset depth1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: latency with all enables on
    step(30'h1, 30'h2, 1, 1, 0, 1, 0);
    step(30'h3, 30'h4, 1, 1, 0, 1, 0);
    step(30'h3FFF_FFFF, 30'h3FFF_FFFF, 1, 1, 0, 1, 0);
    step(30'h5, 30'h6, 1, 1, 0, 1, 0);
    // R5: enables off, hold
    step(30'h7, 30'h8, 0, 0, 0, 0, 0);
    step(30'h9, 30'hA, 0, 1, 0, 0, 0);
    step(30'hB, 30'hC, 1, 0, 0, 0, 0);
    // R6: clear beats enables; R7: local clear ignored by global instance
    step(30'hD, 30'hE, 1, 1, 1, 1, 0);
    step(30'hF, 30'h10, 1, 1, 0, 1, 0);
    // R7/R8: global clear only touches global instance
    step(30'h11, 30'h12, 1, 1, 0, 1, 1);
    step(30'h13, 30'h14, 1, 1, 0, 0, 0);
    step(30'h15, 30'h16, 1, 1, 0, 1, 0);
    for (int i = 0; i < 3000; i++) begin
      step(W'($urandom), W'($urandom),
           ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 16) == 0,
           ($urandom % 3) != 0, ($urandom % 16) == 0);
    end
    // R9: asynchronous reset mid-run
    @(negedge clk);
    check_all();
    rst_n = 1'b0;
    #1;
    cmp(a_op, '0, "R9 async oper");
    cmp(a_cs, '0, "R9 async tap");
    cmp(c_op, '0, "R9 async global");
    cmp(d_op, '0, "R9 async depth1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 50; i++) begin
      step(W'($urandom), W'($urandom), 1, 1, 0, 1, 0);
    end
    @(negedge clk);
    check_all();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule